// File: doc/BRIEF.md
# Exception Pending Control Register

This block is the single 32-bit control and status word that an interrupt controller exposes for its system exceptions. Software uses it to make three system exceptions pending or not pending: the non-maskable interrupt, a deferred-service exception that only software can raise, and the system-timer exception. Each of the three is set by writing 1 to its own bit. The deferred-service and timer exceptions also have a separate write-only bit that clears them. Hardware can raise the non-maskable interrupt and the timer exception. A strobe for each of the three clears its pending state when its handler is entered.

The same word carries live status for reads. It shows whether any ordinary interrupt is pending. It shows the number of the most urgent pending, enabled exception, chosen through a priority arbitration that honours a base-priority threshold and a fault mask. It also shows whether preempted exceptions are waiting below the running one, and the number of the exception that is currently active. The arbitration is combinational from the registered pending state. Read data is registered, so a read returns the state as it stood at the clock edge that captures it.

Top module: `exc_pend_ctl`

## Requirements
- R1: After a synchronous reset all three pending states are 0. With no active exception (act_count = 0, act_num = 0), a read returns 32'h0000_0800.
- R2: A register write with bit 31 = 1 makes the non-maskable interrupt pending, and bit 31 of the read data shows that state. A write with bit 31 = 0 leaves it unchanged.
- R3: A pulse on nmi_enter clears the non-maskable pending state. A pulse on nmi_hw_set sets it, and it wins over nmi_enter in the same cycle, so the bit reads 1 inside the handler only if the input is asserted again.
- R4: A write with bit 28 = 1 is the only way to make the deferred-service exception pending. A write with bit 27 = 1 clears it, and so does a pulse on dsvc_enter. A write with both bits at 1 leaves it at 0. Bit 28 reads back its state.
- R5: A write with bit 26 = 1 or a pulse on tick_hw_set makes the timer exception pending. A write with bit 25 = 1 or a pulse on tick_enter clears it. tick_hw_set wins over a clear in the same cycle. Bit 26 reads back its state.
- R6: Bits 27 and 25 are write-only and read as 0. Reserved bits 30:29, 24, 23, 21 and 10:9 read as 0.
- R7: Bit 22 reads 1 when the deferred-service exception, the timer exception or any external interrupt is pending, whether the interrupt is enabled or not. The non-maskable interrupt does not count.
- R8: Bits 20:12 read the number of the most urgent pending exception. The non-maskable interrupt (number 2) always wins. Otherwise the field holds the lowest priority value among the deferred-service exception (number 14), the timer exception (number 15) and the enabled pending external interrupts (number 16+i). A tie goes to the lower number. The field reads 0 when nothing qualifies.
- R9: When base_mask is nonzero, a candidate whose priority value is greater than or equal to base_mask is excluded from R8. The non-maskable interrupt is not excluded.
- R10: While fault_mask is 1, only the non-maskable interrupt can appear in bits 20:12.
- R11: Bit 11 reads 1 when act_count is 0 or 1, and reads 0 when act_count is 2 or more.
- R12: Bits 8:0 read act_num, the active exception number, where 0 means thread mode.
- R13: A write with bus_we low, or one addressed anywhere other than REG_ADDR, changes no pending state. A read cycle addressed elsewhere returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, 0 when bus_addr is not REG_ADDR |
| nmi_hw_set | input | 1 | Hardware non-maskable interrupt request pulse |
| nmi_enter | input | 1 | Non-maskable handler entry strobe |
| dsvc_enter | input | 1 | Deferred-service handler entry strobe |
| tick_hw_set | input | 1 | Timer expiry pulse |
| tick_enter | input | 1 | Timer handler entry strobe |
| dsvc_prio | input | PRIO_W | Deferred-service priority value (lower is more urgent) |
| tick_prio | input | PRIO_W | Timer priority value |
| ext_pend | input | NUM_EXT | External interrupt pending flags |
| ext_en | input | NUM_EXT | External interrupt enable flags |
| ext_prio | input | NUM_EXT*PRIO_W | Packed external priorities, interrupt i in bits [i*PRIO_W +: PRIO_W] |
| base_mask | input | PRIO_W | Base-priority threshold, 0 disables it |
| fault_mask | input | 1 | Masks everything except the non-maskable interrupt |
| act_num | input | 9 | Number of the running exception, 0 for thread mode |
| act_count | input | CNT_W | Number of exceptions currently active |

## Verification
The assertions assume that the entry and hardware-set inputs are pulses sampled on the clock edge, and that a handler-entry strobe does not arrive in the same cycle as a software set of the same exception, except where the property excludes that case itself. They also assume that act_count and act_num are stable whenever the register is read. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It raises simultaneous events only in the combinations that the requirements define (set with clear, hardware set with clear, hardware set with entry), and it returns the priority and mask inputs to idle values between scenarios.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef logic [8:0] exc_num_t;

  localparam int EXC_NMI      = 2;
  localparam int EXC_DSVC     = 14;
  localparam int EXC_TICK     = 15;
  localparam int EXC_EXT_BASE = 16;

  // Bit positions decoded by software drivers
  localparam int B_NMI_SET   = 31;
  localparam int B_DSVC_SET  = 28;
  localparam int B_DSVC_CLR  = 27;
  localparam int B_TICK_SET  = 26;
  localparam int B_TICK_CLR  = 25;
  localparam int B_ISR_PEND  = 22;
  localparam int B_NUM_LO    = 12;
  localparam int B_RET_BASE  = 11;

endpackage

// File: rtl/epc_pend_bit.sv
// One pending flop. Precedence: hardware set, then any clear, then software set.
module epc_pend_bit (
  input  logic clk,
  input  logic rst,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic entry_clr,
  input  logic hw_set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)                        q <= 1'b0;
    else if (hw_set)                q <= 1'b1;
    else if (sw_clr || entry_clr)   q <= 1'b0;
    else if (sw_set)                q <= 1'b1;
  end
endmodule

// File: rtl/epc_arbiter.sv
// Combinational selection of the most urgent pending enabled exception.
module epc_arbiter
  import epc_pkg::*;
#(
  parameter int NUM_EXT = 16,
  parameter int PRIO_W  = 3
) (
  input  logic                      nmi_pend,
  input  logic                      dsvc_pend,
  input  logic                      tick_pend,
  input  logic [PRIO_W-1:0]         dsvc_prio,
  input  logic [PRIO_W-1:0]         tick_prio,
  input  logic [NUM_EXT-1:0]        ext_pend,
  input  logic [NUM_EXT-1:0]        ext_en,
  input  logic [NUM_EXT*PRIO_W-1:0] ext_prio,
  input  logic [PRIO_W-1:0]         base_mask,
  input  logic                      fault_mask,
  output exc_num_t                  pend_num
);
  localparam int NCAND = NUM_EXT + 2;

  logic     [NCAND-1:0]  raw_v;
  logic     [NCAND-1:0]  qual;
  logic     [PRIO_W-1:0] cand_p [NCAND];
  exc_num_t              cand_n [NCAND];

  // Candidates are listed in ascending exception number so a strict
  // comparison keeps the lower number on a tie.
  assign raw_v[0]  = dsvc_pend;
  assign cand_p[0] = dsvc_prio;
  assign cand_n[0] = exc_num_t'(EXC_DSVC);
  assign raw_v[1]  = tick_pend;
  assign cand_p[1] = tick_prio;
  assign cand_n[1] = exc_num_t'(EXC_TICK);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    assign raw_v[i+2]  = ext_pend[i] && ext_en[i];
    assign cand_p[i+2] = ext_prio[i*PRIO_W +: PRIO_W];
    assign cand_n[i+2] = exc_num_t'(EXC_EXT_BASE + i);
  end

  for (genvar c = 0; c < NCAND; c++) begin : g_qual
    assign qual[c] = raw_v[c] && !fault_mask &&
                     ((base_mask == '0) || (cand_p[c] < base_mask));
  end

  logic              best_v;
  logic [PRIO_W-1:0] best_p;
  exc_num_t          best_n;

  always_comb begin
    best_v = 1'b0;
    best_p = '0;
    best_n = '0;
    for (int c = 0; c < NCAND; c++) begin
      if (qual[c] && (!best_v || (cand_p[c] < best_p))) begin
        best_v = 1'b1;
        best_p = cand_p[c];
        best_n = cand_n[c];
      end
    end
    if (nmi_pend)    pend_num = exc_num_t'(EXC_NMI);
    else if (best_v) pend_num = best_n;
    else             pend_num = '0;
  end
endmodule

// File: rtl/epc_readback.sv
// Assembles the status word and registers it for the bus.
module epc_readback
  import epc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_hit,
  input  logic        nmi_pend,
  input  logic        dsvc_pend,
  input  logic        tick_pend,
  input  logic        isr_pend,
  input  exc_num_t    pend_num,
  input  logic [CNT_W-1:0] act_count,
  input  exc_num_t    act_num,
  output logic [31:0] rdata
);
  logic [31:0] word;
  logic        ret_base;

  assign ret_base = (act_count <= CNT_W'(1));

  always_comb begin
    word = '0;
    word[B_NMI_SET]                  = nmi_pend;
    word[B_DSVC_SET]                 = dsvc_pend;
    word[B_TICK_SET]                 = tick_pend;
    word[B_ISR_PEND]                 = isr_pend;
    word[B_NUM_LO +: $bits(exc_num_t)] = pend_num;
    word[B_RET_BASE]                 = ret_base;
    word[$bits(exc_num_t)-1:0]       = act_num;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= word;
    else             rdata <= '0;
  end
endmodule

// File: rtl/exc_pend_ctl.sv
module exc_pend_ctl
  import epc_pkg::*;
#(
  parameter int          NUM_EXT  = 16,
  parameter int          PRIO_W   = 3,
  parameter int          ADDR_W   = 12,
  parameter int          CNT_W    = 4,
  parameter logic [11:0] REG_ADDR = 12'hD04
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      nmi_hw_set,
  input  logic                      nmi_enter,
  input  logic                      dsvc_enter,
  input  logic                      tick_hw_set,
  input  logic                      tick_enter,
  input  logic [PRIO_W-1:0]         dsvc_prio,
  input  logic [PRIO_W-1:0]         tick_prio,
  input  logic [NUM_EXT-1:0]        ext_pend,
  input  logic [NUM_EXT-1:0]        ext_en,
  input  logic [NUM_EXT*PRIO_W-1:0] ext_prio,
  input  logic [PRIO_W-1:0]         base_mask,
  input  logic                      fault_mask,
  input  logic [8:0]                act_num,
  input  logic [CNT_W-1:0]          act_count
);
  localparam int MAX_EXT = 512 - EXC_EXT_BASE;

  initial begin
    if (NUM_EXT < 1 || NUM_EXT > MAX_EXT)
      $error("NUM_EXT out of range");
  end

  logic     addr_hit;
  logic     wr_hit;
  logic     nmi_q;
  logic     dsvc_q;
  logic     tick_q;
  logic     isr_pend;
  exc_num_t pend_num;

  assign addr_hit = (bus_addr == ADDR_W'(REG_ADDR));
  assign wr_hit   = addr_hit && bus_we;

  epc_pend_bit u_nmi (
    .clk(clk), .rst(rst),
    .sw_set(wr_hit && bus_wdata[B_NMI_SET]),
    .sw_clr(1'b0),
    .entry_clr(nmi_enter),
    .hw_set(nmi_hw_set),
    .q(nmi_q)
  );

  epc_pend_bit u_dsvc (
    .clk(clk), .rst(rst),
    .sw_set(wr_hit && bus_wdata[B_DSVC_SET]),
    .sw_clr(wr_hit && bus_wdata[B_DSVC_CLR]),
    .entry_clr(dsvc_enter),
    .hw_set(1'b0),
    .q(dsvc_q)
  );

  epc_pend_bit u_tick (
    .clk(clk), .rst(rst),
    .sw_set(wr_hit && bus_wdata[B_TICK_SET]),
    .sw_clr(wr_hit && bus_wdata[B_TICK_CLR]),
    .entry_clr(tick_enter),
    .hw_set(tick_hw_set),
    .q(tick_q)
  );

  assign isr_pend = dsvc_q || tick_q || (|ext_pend);

  epc_arbiter #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) u_arb (
    .nmi_pend(nmi_q),
    .dsvc_pend(dsvc_q),
    .tick_pend(tick_q),
    .dsvc_prio(dsvc_prio),
    .tick_prio(tick_prio),
    .ext_pend(ext_pend),
    .ext_en(ext_en),
    .ext_prio(ext_prio),
    .base_mask(base_mask),
    .fault_mask(fault_mask),
    .pend_num(pend_num)
  );

  epc_readback #(.CNT_W(CNT_W)) u_rb (
    .clk(clk), .rst(rst),
    .rd_hit(addr_hit && !bus_we),
    .nmi_pend(nmi_q),
    .dsvc_pend(dsvc_q),
    .tick_pend(tick_q),
    .isr_pend(isr_pend),
    .pend_num(pend_num),
    .act_count(act_count),
    .act_num(act_num),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int          ADDR_W   = 12,
  parameter int          CNT_W    = 4,
  parameter logic [11:0] REG_ADDR = 12'hD04
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_hit,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              nmi_hw_set,
  input logic              nmi_enter,
  input logic              dsvc_enter,
  input logic              tick_hw_set,
  input logic              tick_enter,
  input logic              fault_mask,
  input logic [CNT_W-1:0]  act_count,
  input logic              nmi_q,
  input logic              dsvc_q,
  input logic              tick_q,
  input logic [8:0]        pend_num
);
  assert_nmi_sw_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && bus_wdata[31] && !nmi_enter) |=> nmi_q);

  assert_nmi_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (nmi_enter && !nmi_hw_set) |=> !nmi_q);

  assert_nmi_hw_R3: assert property (@(posedge clk) disable iff (rst)
    nmi_hw_set |=> nmi_q);

  assert_dsvc_clr_wins_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_hit && bus_wdata[27]) || dsvc_enter) |=> !dsvc_q);

  assert_dsvc_only_sw_R4: assert property (@(posedge clk) disable iff (rst)
    (!dsvc_q && !(wr_hit && bus_wdata[28])) |=> !dsvc_q);

  assert_tick_hw_wins_R5: assert property (@(posedge clk) disable iff (rst)
    tick_hw_set |=> tick_q);

  assert_tick_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (((wr_hit && bus_wdata[25]) || tick_enter) && !tick_hw_set) |=> !tick_q);

  assert_fault_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (fault_mask && !nmi_q) |-> (pend_num == 9'd0));

  assert_nmi_first_R8: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> (pend_num == 9'd2));

  assert_preempt_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(REG_ADDR) && !bus_we && act_count >= CNT_W'(2))
      |=> !bus_rdata[11]);

  assert_miss_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != ADDR_W'(REG_ADDR)) |=> (bus_rdata == 32'd0));
endmodule

bind exc_pend_ctl epc_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_hit(wr_hit), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .nmi_hw_set(nmi_hw_set), .nmi_enter(nmi_enter), .dsvc_enter(dsvc_enter),
  .tick_hw_set(tick_hw_set), .tick_enter(tick_enter),
  .fault_mask(fault_mask), .act_count(act_count),
  .nmi_q(nmi_q), .dsvc_q(dsvc_q), .tick_q(tick_q), .pend_num(pend_num)
);

// File: tb/tb_exc_pend_ctl.sv
module tb_exc_pend_ctl;
  localparam int          NUM_EXT = 16;
  localparam int          PRIO_W  = 3;
  localparam int          ADDR_W  = 12;
  localparam int          CNT_W   = 4;
  localparam logic [11:0] RADDR   = 12'hD04;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = RADDR;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic nmi_hw_set = 0, nmi_enter = 0, dsvc_enter = 0, tick_hw_set = 0, tick_enter = 0;
  logic [PRIO_W-1:0] dsvc_prio = '0, tick_prio = '0, base_mask = '0;
  logic [NUM_EXT-1:0] ext_pend = '0, ext_en = '0;
  logic [NUM_EXT*PRIO_W-1:0] ext_prio = '0;
  logic fault_mask = 1'b0;
  logic [8:0] act_num = '0;
  logic [CNT_W-1:0] act_count = '0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  exc_pend_ctl #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
                 .CNT_W(CNT_W), .REG_ADDR(RADDR)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_hw_set(nmi_hw_set), .nmi_enter(nmi_enter), .dsvc_enter(dsvc_enter),
    .tick_hw_set(tick_hw_set), .tick_enter(tick_enter),
    .dsvc_prio(dsvc_prio), .tick_prio(tick_prio),
    .ext_pend(ext_pend), .ext_en(ext_en), .ext_prio(ext_prio),
    .base_mask(base_mask), .fault_mask(fault_mask),
    .act_num(act_num), .act_count(act_count)
  );

  // Field layout from the requirements: 31 nmi, 28 dsvc, 26 tick, 22 any,
  // 20:12 number, 11 return-to-base, 8:0 active.
  function automatic logic [31:0] expw(input logic n, input logic d, input logic t,
                                       input logic any, input int num,
                                       input logic ret, input int act);
    logic [31:0] w;
    w = '0;
    w[31] = n; w[28] = d; w[26] = t; w[22] = any;
    w[20:12] = 9'(num); w[11] = ret; w[8:0] = 9'(act);
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    bus_addr = RADDR; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk);
    bus_addr = RADDR; bus_we = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic set_prio(input int i, input int p);
    ext_prio[i*PRIO_W +: PRIO_W] = PRIO_W'(p);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    rd(r);
    check("R1 reset word", r, 32'h0000_0800);
  endtask

  task automatic t_nmi;
    logic [31:0] r;
    wr(32'h0);
    rd(r); check("R2 write zero no effect", r, expw(0,0,0,0,0,1,0));
    wr(32'h8000_0000);
    rd(r); check("R2 nmi set", r, expw(1,0,0,0,2,1,0));
    @(negedge clk); nmi_enter = 1;
    @(negedge clk); nmi_enter = 0;
    rd(r); check("R3 entry clears", r, expw(0,0,0,0,0,1,0));
    @(negedge clk); nmi_hw_set = 1;
    @(negedge clk); nmi_hw_set = 0;
    rd(r); check("R3 hw set", r, expw(1,0,0,0,2,1,0));
    @(negedge clk); nmi_enter = 1; nmi_hw_set = 1;
    @(negedge clk); nmi_enter = 0; nmi_hw_set = 0;
    rd(r); check("R3 reassert in handler", r, expw(1,0,0,0,2,1,0));
    @(negedge clk); nmi_enter = 1;
    @(negedge clk); nmi_enter = 0;
  endtask

  task automatic t_dsvc;
    logic [31:0] r;
    dsvc_prio = 3'd4;
    wr(32'h1000_0000);
    rd(r); check("R4 dsvc set R7 any", r, expw(0,1,0,1,14,1,0));
    wr(32'h0800_0000);
    rd(r); check("R4 dsvc clear", r, expw(0,0,0,0,0,1,0));
    wr(32'h1800_0000);
    rd(r); check("R4 set and clear same write", r, expw(0,0,0,0,0,1,0));
    wr(32'h1000_0000);
    @(negedge clk); dsvc_enter = 1;
    @(negedge clk); dsvc_enter = 0;
    rd(r); check("R4 entry clears", r, expw(0,0,0,0,0,1,0));
  endtask

  task automatic t_tick;
    logic [31:0] r;
    tick_prio = 3'd3;
    wr(32'h0400_0000);
    rd(r); check("R5 tick set", r, expw(0,0,1,1,15,1,0));
    wr(32'h0200_0000);
    rd(r); check("R5 tick clear", r, expw(0,0,0,0,0,1,0));
    @(negedge clk); bus_we = 1; bus_wdata = 32'h0200_0000; tick_hw_set = 1;
    @(negedge clk); bus_we = 0; bus_wdata = '0; tick_hw_set = 0;
    rd(r); check("R5 hw set beats clear", r, expw(0,0,1,1,15,1,0));
    @(negedge clk); tick_enter = 1;
    @(negedge clk); tick_enter = 0;
    rd(r); check("R5 entry clears", r, expw(0,0,0,0,0,1,0));
  endtask

  task automatic t_wo_bits;
    logic [31:0] r;
    wr(32'hFFFF_FFFF);
    rd(r);
    check("R6 write-only and reserved read zero", r & 32'h6BA0_0600, 32'h0);
    check("R4 R5 all-ones write clears", r, expw(1,0,0,0,2,1,0));
    @(negedge clk); nmi_enter = 1;
    @(negedge clk); nmi_enter = 0;
  endtask

  task automatic t_arb;
    logic [31:0] r;
    ext_en = '0; ext_pend = '0;
    set_prio(3, 5); set_prio(6, 2); set_prio(9, 2);
    ext_pend[3] = 1; ext_pend[6] = 1; ext_pend[9] = 1;
    ext_en[3] = 1; ext_en[6] = 1; ext_en[9] = 1;
    rd(r); check("R8 tie lower number", r, expw(0,0,0,1,22,1,0));
    ext_en[6] = 0;
    rd(r); check("R8 disabled skipped", r, expw(0,0,0,1,25,1,0));
    dsvc_prio = 3'd2;
    wr(32'h1000_0000);
    rd(r); check("R8 dsvc ties ext", r, expw(0,1,0,1,14,1,0));
    tick_prio = 3'd1;
    wr(32'h0400_0000);
    rd(r); check("R8 tick most urgent", r, expw(0,1,1,1,15,1,0));
    base_mask = 3'd1;
    rd(r); check("R9 base mask excludes all", r, expw(0,1,1,1,0,1,0));
    base_mask = 3'd2;
    rd(r); check("R9 base mask passes prio 1", r, expw(0,1,1,1,15,1,0));
    wr(32'h8000_0000);
    rd(r); check("R9 nmi not masked", r, expw(1,1,1,1,2,1,0));
    base_mask = '0; fault_mask = 1;
    rd(r); check("R10 fault mask keeps nmi", r, expw(1,1,1,1,2,1,0));
    @(negedge clk); nmi_enter = 1;
    @(negedge clk); nmi_enter = 0;
    rd(r); check("R10 fault mask hides rest", r, expw(0,1,1,1,0,1,0));
    fault_mask = 0;
    wr(32'h0A00_0000);
    ext_en = '0; ext_pend = '0; ext_pend[4] = 1;
    rd(r); check("R7 disabled pending counts", r, expw(0,0,0,1,0,1,0));
    ext_pend = '0;
    rd(r); check("R7 nothing pending", r, expw(0,0,0,0,0,1,0));
  endtask

  task automatic t_active;
    logic [31:0] r;
    act_count = 1; act_num = 9'd18;
    rd(r); check("R11 R12 single active", r, expw(0,0,0,0,0,1,18));
    act_count = 2; act_num = 9'd15;
    rd(r); check("R11 preempted", r, expw(0,0,0,0,0,0,15));
    act_count = 0; act_num = 0;
  endtask

  task automatic t_ignored;
    logic [31:0] r;
    @(negedge clk); bus_addr = RADDR + 12'd4; bus_we = 1; bus_wdata = 32'h9400_0000;
    @(negedge clk); bus_we = 0;
    @(posedge clk); #1 check("R13 other address reads zero", bus_rdata, 32'h0);
    @(negedge clk); bus_addr = RADDR; bus_we = 0; bus_wdata = 32'h9400_0000;
    @(negedge clk); bus_wdata = '0;
    rd(r); check("R13 no state change", r, expw(0,0,0,0,0,1,0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_nmi();
    t_dsvc();
    t_tick();
    t_wo_bits();
    t_arb();
    t_active();
    t_ignored();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule